// File: doc/BRIEF.md
# Match-Action Timer/Counter

This block is a 32-bit up-counter with a programmable prescaler and four compare registers. In timer mode it advances on every core clock cycle, divided by the prescaler. In counter mode it advances on rising edges of an external event input, which first passes through a two-flop synchronizer and an edge detector. Both sources go through the same prescaler.

Each compare register has its own three-bit action field. When the count equals a compare value on a count tick, that field can set a sticky interrupt flag, return the count to zero, stop the counter, or do any mix of the three. A combined interrupt output is the OR of all flags. Software reaches every register through a single-cycle write port and a combinational read port that share one address bus.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, `match_flags` is 0 and `irq` is 0.
- R2: The address map is: 0x0 control, 0x1 count, 0x2 prescale, 0x3 action field, 0x4 flags, and 0x8 plus i for compare register i. A write updates the register on the clock edge. A read returns the value on the next settle. Control reads back in 3 bits and the action field in 12 bits, with the upper bits zero. Unmapped addresses read zero.
- R3: Control bit 0 is the enable. While it is 1 and control bit 1 is 0, each tick adds one to the count, and the count wraps from 0xFFFFFFFF to 0.
- R4: While control bit 0 is 0, the count holds its value.
- R5: While control bit 1 is 1, the count and the prescale counter are forced to zero on every edge.
- R6: With prescale value P, a tick occurs on every (P+1)-th source event. A value of 0 gives one tick per event.
- R7: The action field holds 3 bits per compare register, with register 0 in bits 2:0 and register i in bits 3i+2:3i. Within each group, bit 0 is interrupt, bit 1 is reset-to-zero and bit 2 is stop. Several compare registers can act on the same tick.
- R8: Reset-on-match loads zero on the tick where the count equals the compare value N, which gives a period of N+1 ticks.
- R9: Stop-on-match clears control bit 0 on that tick and leaves the count at the compared value. A control write in the same cycle takes priority.
- R10: A flag bit sets on a tick where its compare register matches and its interrupt bit is on. It stays set until software writes 1 to that bit at address 0x4. Writing 0 has no effect, and a new set in the same cycle wins over a clear.
- R11: `irq` is high exactly when any flag bit is set.
- R12: Control bit 2 selects counter mode. In that mode, each low-to-high transition of `ext_evt` counts as one source event, seen three edges after it occurs. A level held high counts once.
- R13: A write to the count register loads the written value and takes priority over counting and over control bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_evt | input | 1 | External event input for counter mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| match_flags | output | 4 | Sticky per-compare interrupt flags |
| irq | output | 1 | OR of all flags |

## Verification
The count is driven through the enable and reset bits, a wrap from 0xFFFFFFFE, and a prescale of 2. This separates off-by-one tick placement from simple gating errors. Compare actions are tried as reset-plus-interrupt on register 0, stop-plus-interrupt on register 1, and two registers matching the same value with different action bits. Together these show whether the field layout, the N+1 period and the freeze point are right. Counter mode is driven with short pulses and then a long high level, which separates edge counting from level counting. A behavioural model in the bench tracks flags and readback on every cycle.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL       = 4'h0;
  localparam logic [ADDR_W-1:0] A_COUNT      = 4'h1;
  localparam logic [ADDR_W-1:0] A_PRESC      = 4'h2;
  localparam logic [ADDR_W-1:0] A_ACT        = 4'h3;
  localparam logic [ADDR_W-1:0] A_FLAGS      = 4'h4;
  localparam logic [ADDR_W-1:0] A_MATCH_BASE = 4'h8;

  localparam int CTRL_W  = 3;
  localparam int CB_EN   = 0;
  localparam int CB_CLR  = 1;
  localparam int CB_MODE = 2;

  localparam int ACT_W    = 3;
  localparam int ACT_INT  = 0;
  localparam int ACT_RST  = 1;
  localparam int ACT_STOP = 2;
endpackage

// File: rtl/mt_edge_sync.sv
module mt_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb sh_d = {sh_q[1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // stage 1 is the synchronized level, stage 2 its one-cycle delay
  assign rise_pulse = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         src_evt,
  input  logic         hold_zero,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pc_q, pc_d;
  logic         pc_en;

  always_comb begin
    tick  = run & src_evt & (pc_q == limit);
    pc_en = hold_zero | (run & src_evt);
    pc_d  = pc_q;
    if (hold_zero)           pc_d = '0;
    else if (run && src_evt) pc_d = tick ? '0 : pc_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end
endmodule

// File: rtl/mt_match_bank.sv
module mt_match_bank import mt_pkg::*; #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic [W-1:0]       count,
  input  logic [N*W-1:0]     match_flat,
  input  logic [ACT_W*N-1:0] act_sel,
  input  logic               tick,
  output logic [N-1:0]       int_set,
  output logic               any_reset,
  output logic               any_stop
);
  logic [N-1:0] fire, rst_req, stp_req;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign fire[i]    = tick & (count == match_flat[i*W +: W]);
    assign int_set[i] = fire[i] & act_sel[ACT_W*i + ACT_INT];
    assign rst_req[i] = fire[i] & act_sel[ACT_W*i + ACT_RST];
    assign stp_req[i] = fire[i] & act_sel[ACT_W*i + ACT_STOP];
  end

  assign any_reset = |rst_req;
  assign any_stop  = |stp_req;
endmodule

// File: rtl/match_timer.sv
module match_timer import mt_pkg::*; #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_evt,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   rd_data,
  output logic [N_MATCH-1:0] match_flags,
  output logic               irq
);
  localparam int ACT_BITS = ACT_W * N_MATCH;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic [CTRL_W-1:0]   ctrl_q, ctrl_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CNT_W-1:0]    pre_q;
  logic [ACT_BITS-1:0] act_q;
  logic [N_MATCH-1:0]  flg_q, flg_d, flg_clr;
  logic [CNT_W-1:0]    match_q [N_MATCH];
  logic [N_MATCH*CNT_W-1:0] match_flat;

  logic we_ctrl, we_cnt, we_pre, we_act, we_flg;
  logic [N_MATCH-1:0] we_mt;
  logic ctrl_en, cnt_en, flg_en;

  logic ext_pulse, src_evt, run, tick;
  logic [N_MATCH-1:0] int_set;
  logic any_reset, any_stop;

  // write decode
  always_comb begin
    we_ctrl = wr_en && (addr == A_CTRL);
    we_cnt  = wr_en && (addr == A_COUNT);
    we_pre  = wr_en && (addr == A_PRESC);
    we_act  = wr_en && (addr == A_ACT);
    we_flg  = wr_en && (addr == A_FLAGS);
    for (int i = 0; i < N_MATCH; i++)
      we_mt[i] = wr_en && (addr == A_MATCH_BASE + ADDR_W'(i));
  end

  for (genvar i = 0; i < N_MATCH; i++) begin : g_flat
    assign match_flat[i*CNT_W +: CNT_W] = match_q[i];
  end

  mt_edge_sync u_sync (
    .clk(clk), .rst_n(srst_n), .async_in(ext_evt), .rise_pulse(ext_pulse)
  );

  assign run     = ctrl_q[CB_EN] & ~ctrl_q[CB_CLR];
  assign src_evt = ctrl_q[CB_MODE] ? ext_pulse : 1'b1;

  mt_prescaler #(.W(CNT_W)) u_presc (
    .clk(clk), .rst_n(srst_n), .run(run), .src_evt(src_evt),
    .hold_zero(ctrl_q[CB_CLR]), .limit(pre_q), .tick(tick)
  );

  mt_match_bank #(.W(CNT_W), .N(N_MATCH)) u_bank (
    .count(cnt_q), .match_flat(match_flat), .act_sel(act_q), .tick(tick),
    .int_set(int_set), .any_reset(any_reset), .any_stop(any_stop)
  );

  // next state
  always_comb begin
    ctrl_en = we_ctrl | any_stop;
    ctrl_d  = ctrl_q;
    if (we_ctrl)       ctrl_d = wr_data[CTRL_W-1:0];
    else if (any_stop) ctrl_d[CB_EN] = 1'b0;

    cnt_en = we_cnt | ctrl_q[CB_CLR] | tick;
    cnt_d  = cnt_q;
    if (we_cnt)              cnt_d = wr_data;
    else if (ctrl_q[CB_CLR]) cnt_d = '0;
    else if (any_reset)      cnt_d = '0;
    else if (!any_stop)      cnt_d = cnt_q + CNT_W'(1);

    flg_clr = we_flg ? wr_data[N_MATCH-1:0] : '0;
    flg_d   = (flg_q & ~flg_clr) | int_set;
    flg_en  = we_flg | (|int_set);
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      act_q  <= '0;
      flg_q  <= '0;
      for (int i = 0; i < N_MATCH; i++) match_q[i] <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (we_pre)  pre_q  <= wr_data;
      if (we_act)  act_q  <= wr_data[ACT_BITS-1:0];
      if (flg_en)  flg_q  <= flg_d;
      for (int i = 0; i < N_MATCH; i++)
        if (we_mt[i]) match_q[i] <= wr_data;
    end
  end

  // read mux
  always_comb begin
    case (addr)
      A_CTRL:  rd_data = CNT_W'(ctrl_q);
      A_COUNT: rd_data = cnt_q;
      A_PRESC: rd_data = pre_q;
      A_ACT:   rd_data = CNT_W'(act_q);
      A_FLAGS: rd_data = CNT_W'(flg_q);
      default: rd_data = '0;
    endcase
    for (int i = 0; i < N_MATCH; i++)
      if (addr == A_MATCH_BASE + ADDR_W'(i)) rd_data = match_q[i];
  end

  assign match_flags = flg_q;
  assign irq         = |flg_q;
endmodule

// File: rtl/mt_checker.sv
module mt_checker import mt_pkg::*; #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4
) (
  input logic               clk,
  input logic               srst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [CNT_W-1:0]   wr_data,
  input logic [CTRL_W-1:0]  ctrl_q,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               tick,
  input logic               stop_hit,
  input logic [N_MATCH-1:0] flags
);
  logic cnt_wr, ctrl_wr, flg_wr;
  logic [N_MATCH-1:0] keep;
  assign cnt_wr  = wr_en && (addr == A_COUNT);
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign flg_wr  = wr_en && (addr == A_FLAGS);
  assign keep    = flags & ~(flg_wr ? wr_data[N_MATCH-1:0] : '0);

  // R13
  cnt_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_wr |=> cnt_q == $past(wr_data));

  // R5
  clr_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_q[CB_CLR] && !cnt_wr) |=> cnt_q == '0);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!ctrl_q[CB_EN] && !ctrl_q[CB_CLR] && !cnt_wr) |=> $stable(cnt_q));

  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_q[CB_EN] && !ctrl_q[CB_CLR] && !cnt_wr) |=>
      (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0) || $stable(cnt_q));

  // R9
  stop_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (stop_hit && !ctrl_wr) |=> !ctrl_q[CB_EN]);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (|keep) |=> ((flags & $past(keep)) == $past(keep)));

  // R10
  flag_on_tick_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !tick |=> ((flags & ~$past(flags)) == '0));
endmodule

bind match_timer mt_checker #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chk (
  .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q), .tick(tick), .stop_hit(any_stop),
  .flags(match_flags)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_evt = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic [3:0]  flags;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #5 clk = ~clk;

  match_timer u0 (
    .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .match_flags(flags), .irq(irq)
  );

  // behavioural reference model
  logic [2:0]  m_ctrl = '0;
  logic [31:0] m_cnt = '0, m_pre = '0, m_pc = '0;
  logic [11:0] m_act = '0;
  logic [3:0]  m_flags = '0;
  logic [31:0] m_mt [4] = '{default: '0};
  logic        m_s1 = 0, m_s2 = 0, m_s3 = 0, m_r1 = 0, m_r2 = 0;

  always @(posedge clk) begin
    logic live, ev, act, src, tk, rs, st;
    logic [3:0] nf, clr;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; live = 0;
    end else begin
      live = m_r2; m_r2 = m_r1; m_r1 = 1;
    end
    if (!live) begin
      m_ctrl = 0; m_cnt = 0; m_pre = 0; m_pc = 0; m_act = 0; m_flags = 0;
      for (int i = 0; i < 4; i++) m_mt[i] = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      ev = m_s2 & ~m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_evt;
      act = m_ctrl[0] & ~m_ctrl[1];
      src = m_ctrl[2] ? ev : 1'b1;
      tk  = act && src && (m_pc == m_pre);
      nf = 0; rs = 0; st = 0;
      for (int i = 0; i < 4; i++)
        if (tk && m_cnt == m_mt[i]) begin
          nf[i] = m_act[3*i];
          rs |= m_act[3*i+1];
          st |= m_act[3*i+2];
        end
      clr = (wr_en && addr == 4'h4) ? wr_data[3:0] : 4'h0;
      if (m_ctrl[1])      m_pc = 0;
      else if (act && src) m_pc = tk ? 0 : m_pc + 1;
      if (wr_en && addr == 4'h1) m_cnt = wr_data;
      else if (m_ctrl[1])        m_cnt = 0;
      else if (tk)               m_cnt = rs ? 0 : (st ? m_cnt : m_cnt + 1);
      if (wr_en && addr == 4'h0) m_ctrl = wr_data[2:0];
      else if (tk && st)         m_ctrl[0] = 1'b0;
      m_flags = (m_flags & ~clr) | nf;
      if (wr_en && addr == 4'h2) m_pre = wr_data;
      if (wr_en && addr == 4'h3) m_act = wr_data[11:0];
      for (int i = 0; i < 4; i++)
        if (wr_en && addr == 4'(8 + i)) m_mt[i] = wr_data;
    end
  end

  function automatic logic [31:0] m_rd(logic [3:0] a);
    case (a)
      4'h0: return {29'b0, m_ctrl};
      4'h1: return m_cnt;
      4'h2: return m_pre;
      4'h3: return {20'b0, m_act};
      4'h4: return {28'b0, m_flags};
      4'h8, 4'h9, 4'hA, 4'hB: return m_mt[a[1:0]];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R10 flags vs model", {28'b0, flags}, {28'b0, m_flags});
      chk("R11 irq vs model", {31'b0, irq}, {31'b0, |m_flags});
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'h0;
  endtask

  // read against the model and against a hand-derived value
  task automatic rdh(logic [3:0] a, logic [31:0] exp, string tag);
    addr = a;
    #1;
    chk({tag, " model"}, rd_data, m_rd(a));
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse();
    ext_evt = 1'b1; step(3);
    ext_evt = 1'b0; step(3);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      report();
    end
  end

  initial begin
    @(negedge clk);
    cmp_on = 1;
    step(2);
    rst_n = 1'b1;
    step(3);

    // R1 reset state
    rdh(4'h0, 0, "R1 ctrl");
    rdh(4'h1, 0, "R1 count");
    rdh(4'h4, 0, "R1 flags");
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 readback and field widths
    wr(4'h2, 32'h1234_5678);
    rdh(4'h2, 32'h1234_5678, "R2 prescale");
    wr(4'h3, 32'hFFFF_FFFF);
    rdh(4'h3, 32'h0000_0FFF, "R2 action width");
    wr(4'h0, 32'hFFFF_FFF8);
    rdh(4'h0, 0, "R2 ctrl width");
    wr(4'hA, 32'hCAFE_0002);
    rdh(4'hA, 32'hCAFE_0002, "R2 compare2");
    rdh(4'h6, 0, "R2 unmapped");
    wr(4'h3, 0); wr(4'h2, 0); wr(4'hA, 0);

    // R3 counting
    wr(4'h0, 1);
    step(3);
    rdh(4'h1, 3, "R3 count");

    // R4 hold when disabled
    wr(4'h0, 0);
    step(5);
    rdh(4'h1, 4, "R4 hold");

    // R5 reset bit holds zero
    wr(4'h0, 3);
    step(4);
    rdh(4'h1, 0, "R5 held zero");

    // R13 load and R3 wrap
    wr(4'h0, 0);
    wr(4'h1, 32'hFFFF_FFFE);
    rdh(4'h1, 32'hFFFF_FFFE, "R13 load");
    wr(4'h0, 1);
    step(2);
    rdh(4'h1, 0, "R3 wrap");

    // R6 prescale of 2
    wr(4'h0, 2);
    wr(4'h2, 2);
    wr(4'h0, 1);
    step(7);
    rdh(4'h1, 2, "R6 div3 a");
    step(2);
    rdh(4'h1, 3, "R6 div3 b");

    // R8 reset-on-match with interrupt, R10, R11
    wr(4'h0, 2);
    wr(4'h2, 0);
    wr(4'h8, 4);
    wr(4'h3, 32'h3);
    wr(4'h0, 1);
    step(4);
    rdh(4'h1, 4, "R8 at compare");
    chk("R10 no flag yet", {28'b0, flags}, 0);
    step(1);
    rdh(4'h1, 0, "R8 reload");
    chk("R10 flag0 set", {28'b0, flags}, 1);
    chk("R11 irq high", {31'b0, irq}, 1);
    step(5);
    rdh(4'h1, 0, "R8 period five");
    wr(4'h4, 0);
    chk("R10 write zero keeps", {28'b0, flags}, 1);
    wr(4'h4, 1);
    chk("R10 w1c", {28'b0, flags}, 0);
    chk("R11 irq low", {31'b0, irq}, 0);

    // R9 stop-on-match on compare1, R7 layout
    wr(4'h0, 2);
    wr(4'h3, 32'h28);
    wr(4'h9, 3);
    wr(4'h0, 1);
    step(6);
    rdh(4'h1, 3, "R9 frozen");
    rdh(4'h0, 0, "R9 enable cleared");
    chk("R7 flag1 only", {28'b0, flags}, 2);
    wr(4'h4, 2);

    // R12 counter mode
    wr(4'h0, 2);
    wr(4'h3, 0);
    wr(4'h0, 5);
    for (int k = 0; k < 4; k++) pulse();
    step(2);
    rdh(4'h1, 4, "R12 four edges");
    ext_evt = 1'b1;
    step(10);
    rdh(4'h1, 5, "R12 level once");
    ext_evt = 1'b0;
    step(3);

    // R7 two compares on one tick
    wr(4'h0, 2);
    wr(4'h3, 32'h640);
    wr(4'hA, 2);
    wr(4'hB, 2);
    wr(4'h4, 4'hF);
    wr(4'h0, 1);
    step(3);
    chk("R7 both flags", {28'b0, flags}, 32'hC);
    rdh(4'h1, 0, "R7 reset from compare3");

    step(2);
    done = 1;
    report();
  end
endmodule